// File: doc/BRIEF.md
# Ethernet MAC Transmit Flow Controller

This block decides, cycle by cycle, whether an Ethernet MAC transmitter may begin its next data frame. Software programs a small control register with five bits: graceful stop, send-pause, full duplex, heartbeat check and a read-only received-pause flag. The transmit engine reports the start and end of each data frame and the completion of a MAC Control PAUSE frame. The receive side reports an incoming PAUSE frame together with its quanta value. The line supplies carrier sense and collision.

The block returns a data-frame permit and a request to send a PAUSE frame. It also provides a sticky graceful-stop-complete interrupt, the received-pause status and a sticky heartbeat-error flag. A single bit-time tick input paces both the received-pause timer and the heartbeat window. Serialization, CRC, FIFO handling and MII signalling are left to the surrounding MAC.

Top module: `eth_txfc`

## Requirements
- R1: After reset every control bit, the interrupt, the heartbeat error, the pause request and the received-pause status are 0. `reg_rdata` shows the register as bit 0 graceful stop, bit 1 heartbeat enable, bit 2 full duplex, bit 3 received-pause status and bit 4 send-pause, with bits 31..5 always 0.
- R2: A write to bit 2 (full duplex) or bit 1 (heartbeat enable) takes effect only while `mac_en` is 0. At other times those bits keep their value. Bit 3 is never changed by a write.
- R3: While graceful stop (bit 0) is 1 or a data frame is active (between `frm_start` and `frm_done`), `tx_permit` is 0. `gsc_irq` rises on the clock edge after the first edge at which a stop bit (bit 0 or bit 4) is 1 and no data frame is active. If the block is idle, this is the second edge after the write.
- R4: Writing 0 to graceful stop returns `tx_permit` to 1 right after the write edge, provided nothing else blocks it.
- R5: Writing 1 to bit 4 sets send-pause, and writing 0 to it has no effect. Once no data frame is active, `pause_req` and `gsc_irq` rise together. `pause_req` stays 1 until `pause_done`. That edge clears bit 4 and `pause_req`, and data frames may then resume.
- R6: A send-pause request raises `pause_req` even while graceful stop is set or a received pause is running.
- R7: An `rx_pause_vld` pulse with a nonzero quanta Q, taken while full duplex and `mac_en` are both 1, sets `rx_paused` and blocks `tx_permit` for exactly Q*512 `bit_tick` edges. `rx_paused` then clears. In half duplex the pulse is ignored.
- R8: A new received PAUSE during a pause restarts the count from its own quanta. A quanta of 0 ends the pause at that edge.
- R9: In half duplex `tx_permit` is 0 while `crs` is 1. In full duplex `crs` has no effect. `tx_permit` is always 0 while `mac_en` is 0.
- R10: In half duplex with heartbeat enabled, each `frm_done` opens a window of HB_WIN bit ticks. If `col` stays 0 through that window, `hb_err` is set on the HB_WIN-th tick edge. A `col` pulse inside the window prevents the error.
- R11: `gsc_irq` and `hb_err` hold until a pulse on `stat_clr[0]` or `stat_clr[1]` respectively clears them. A new set event in the same cycle wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mac_en | input | 1 | MAC enable; locks the duplex and heartbeat bits while high |
| reg_wr | input | 1 | Control register write strobe |
| reg_wdata | input | 5 | Control register write data, bits 4..0 |
| reg_rdata | output | 32 | Control register read image |
| stat_clr | input | 2 | Write-one-to-clear pulse: bit 0 clears the interrupt, bit 1 clears the heartbeat error |
| frm_start | input | 1 | Transmit engine began a data frame |
| frm_done | input | 1 | Data frame ended, normally or by collision |
| pause_done | input | 1 | Requested PAUSE frame has been sent |
| rx_pause_vld | input | 1 | A PAUSE frame was received |
| rx_pause_quanta | input | 16 | Quanta value of the received PAUSE frame |
| bit_tick | input | 1 | One pulse per bit time |
| crs | input | 1 | Carrier sense |
| col | input | 1 | Collision |
| tx_permit | output | 1 | A data frame may start |
| pause_req | output | 1 | Send one MAC Control PAUSE frame |
| gsc_irq | output | 1 | Graceful-stop-complete interrupt, sticky |
| rx_paused | output | 1 | Received pause in progress |
| hb_err | output | 1 | Heartbeat missing, sticky |

## Verification
A wrong stop flag or frame-activity state shows at once as `tx_permit` being high while a frame runs or a stop is set. It also shows as `gsc_irq` arriving one edge too early or never. A miscounted pause timer is seen only at the end of the pause, so the bench samples `rx_paused` one edge before and one edge after the exact Q*512 boundary. A heartbeat counter that is off by one is caught the same way, at edge HB_WIN-1 against edge HB_WIN. A send-pause handshake that drops its request, or never clears bit 4, is visible on `pause_req` and `reg_rdata` within one cycle of `pause_done`.

// File: rtl/eth_txfc_pkg.sv
package eth_txfc_pkg;

  localparam int CB_GTS  = 0;
  localparam int CB_HBEN = 1;
  localparam int CB_FDX  = 2;
  localparam int CB_RXP  = 3;
  localparam int CB_TXP  = 4;
  localparam int CB_NUM  = 5;

  typedef struct packed {
    logic txp;   // send-pause request
    logic rxp;   // received pause active (read only)
    logic fdx;   // full duplex
    logic hben;  // heartbeat check enable
    logic gts;   // graceful stop
  } ctl_t;

  // Read image of the control word: reserved bits are zero.
  function automatic logic [31:0] reg_image(input ctl_t c);
    logic [31:0] r;
    r = '0;
    r[CB_GTS]  = c.gts;
    r[CB_HBEN] = c.hben;
    r[CB_FDX]  = c.fdx;
    r[CB_RXP]  = c.rxp;
    r[CB_TXP]  = c.txp;
    return r;
  endfunction

  // True on the last count of a window of lim steps starting at zero.
  function automatic logic at_last(input logic [31:0] cnt, input int lim);
    return cnt == 32'(lim - 1);
  endfunction

  // Total bit ticks a received pause lasts.
  function automatic logic [31:0] pause_ticks(input logic [15:0] q, input int slot);
    return 32'(q) * 32'(slot);
  endfunction

endpackage

// File: rtl/eth_txfc_pause_tmr.sv
module eth_txfc_pause_tmr #(
  parameter int QW   = 16,
  parameter int SLOT = 512
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [QW-1:0] quanta,
  input  logic          bit_tick,
  output logic          paused,
  output logic          slot_end
);
  import eth_txfc_pkg::*;

  localparam int SW = (SLOT > 1) ? $clog2(SLOT) : 1;

  logic [SW-1:0] sub_q;
  logic [QW-1:0] left_q;
  logic          act_q;

  assign slot_end = act_q && bit_tick && at_last(32'(sub_q), SLOT);
  assign paused   = act_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      sub_q  <= '0;
      left_q <= '0;
    end else if (load) begin
      act_q  <= (quanta != '0);
      left_q <= quanta;
      sub_q  <= '0;
    end else if (act_q && bit_tick) begin
      if (slot_end) begin
        sub_q <= '0;
        if (left_q == QW'(1)) act_q <= 1'b0;
        else                  left_q <= left_q - QW'(1);
      end else begin
        sub_q <= sub_q + SW'(1);
      end
    end
  end

endmodule

// File: rtl/eth_txfc_hb_win.sv
module eth_txfc_hb_win #(
  parameter int HB_WIN = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic col,
  input  logic bit_tick,
  input  logic clr,
  output logic open,
  output logic miss,
  output logic err
);
  import eth_txfc_pkg::*;

  localparam int HW = (HB_WIN > 1) ? $clog2(HB_WIN) : 1;

  logic [HW-1:0] cnt_q;
  logic          open_q;
  logic          err_q;

  assign miss = open_q && !col && bit_tick && at_last(32'(cnt_q), HB_WIN);
  assign open = open_q;
  assign err  = err_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      cnt_q  <= '0;
    end else if (start) begin
      open_q <= 1'b1;
      cnt_q  <= '0;
    end else if (open_q) begin
      if (col || miss)   open_q <= 1'b0;
      else if (bit_tick) cnt_q  <= cnt_q + HW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)   err_q <= 1'b0;
    else if (miss) err_q <= 1'b1;
    else if (clr)  err_q <= 1'b0;
  end

endmodule

// File: rtl/eth_txfc_seq.sv
module eth_txfc_seq
  import eth_txfc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mac_en,
  input  logic              reg_wr,
  input  logic [CB_NUM-1:0] reg_wdata,
  input  logic              irq_clr,
  input  logic              frm_start,
  input  logic              frm_done,
  input  logic              pause_done,
  input  logic              crs,
  input  logic              rx_paused,
  output ctl_t              ctl,
  output logic              data_busy,
  output logic              stop_cond,
  output logic              stop_evt,
  output logic              tx_permit,
  output logic              pause_req,
  output logic              gsc_irq
);

  logic gts_q, txp_q, fdx_q, hben_q;
  logic busy_q, stop_q, preq_q, irq_q;
  logic preq_set;

  assign data_busy = busy_q;
  assign stop_cond = (gts_q || txp_q) && !busy_q;
  assign stop_evt  = stop_cond && !stop_q;
  assign preq_set  = txp_q && !busy_q && !preq_q && mac_en;

  assign ctl = '{txp: txp_q, rxp: rx_paused, fdx: fdx_q, hben: hben_q, gts: gts_q};

  assign tx_permit = mac_en && !busy_q && !gts_q && !txp_q && !preq_q &&
                     !rx_paused && (fdx_q || !crs);
  assign pause_req = preq_q;
  assign gsc_irq   = irq_q;

  // software-visible control bits
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gts_q  <= 1'b0;
      txp_q  <= 1'b0;
      fdx_q  <= 1'b0;
      hben_q <= 1'b0;
    end else begin
      if (reg_wr) gts_q <= reg_wdata[CB_GTS];
      if (reg_wr && !mac_en) begin
        fdx_q  <= reg_wdata[CB_FDX];
        hben_q <= reg_wdata[CB_HBEN];
      end
      if (reg_wr && reg_wdata[CB_TXP]) txp_q <= 1'b1;
      else if (pause_done && preq_q)   txp_q <= 1'b0;
    end
  end

  // frame activity, stop edge, pause handshake, interrupt
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      stop_q <= 1'b0;
      preq_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      if (frm_start)     busy_q <= 1'b1;
      else if (frm_done) busy_q <= 1'b0;
      stop_q <= stop_cond;
      if (preq_set)        preq_q <= 1'b1;
      else if (pause_done) preq_q <= 1'b0;
      if (stop_evt)     irq_q <= 1'b1;
      else if (irq_clr) irq_q <= 1'b0;
    end
  end

endmodule

// File: rtl/eth_txfc.sv
module eth_txfc
  import eth_txfc_pkg::*;
#(
  parameter int QUANTA_W   = 16,
  parameter int SLOT_TICKS = 512,
  parameter int HB_WIN     = 64
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                mac_en,
  input  logic                reg_wr,
  input  logic [4:0]          reg_wdata,
  output logic [31:0]         reg_rdata,
  input  logic [1:0]          stat_clr,
  input  logic                frm_start,
  input  logic                frm_done,
  input  logic                pause_done,
  input  logic                rx_pause_vld,
  input  logic [QUANTA_W-1:0] rx_pause_quanta,
  input  logic                bit_tick,
  input  logic                crs,
  input  logic                col,
  output logic                tx_permit,
  output logic                pause_req,
  output logic                gsc_irq,
  output logic                rx_paused,
  output logic                hb_err
);

  ctl_t ctl;
  logic gts_bit, fdx_bit, hben_bit;
  logic data_busy, stop_cond, stop_evt;
  logic rxp_load, slot_end;
  logic hb_start, hb_open, hb_miss;

  assign gts_bit  = ctl.gts;
  assign fdx_bit  = ctl.fdx;
  assign hben_bit = ctl.hben;

  assign rxp_load = rx_pause_vld && fdx_bit && mac_en;
  assign hb_start = frm_done && hben_bit && !fdx_bit;

  eth_txfc_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .mac_en     (mac_en),
    .reg_wr     (reg_wr),
    .reg_wdata  (reg_wdata),
    .irq_clr    (stat_clr[0]),
    .frm_start  (frm_start),
    .frm_done   (frm_done),
    .pause_done (pause_done),
    .crs        (crs),
    .rx_paused  (rx_paused),
    .ctl        (ctl),
    .data_busy  (data_busy),
    .stop_cond  (stop_cond),
    .stop_evt   (stop_evt),
    .tx_permit  (tx_permit),
    .pause_req  (pause_req),
    .gsc_irq    (gsc_irq)
  );

  eth_txfc_pause_tmr #(.QW(QUANTA_W), .SLOT(SLOT_TICKS)) u_ptmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (rxp_load),
    .quanta   (rx_pause_quanta),
    .bit_tick (bit_tick),
    .paused   (rx_paused),
    .slot_end (slot_end)
  );

  eth_txfc_hb_win #(.HB_WIN(HB_WIN)) u_hb (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (hb_start),
    .col      (col),
    .bit_tick (bit_tick),
    .clr      (stat_clr[1]),
    .open     (hb_open),
    .miss     (hb_miss),
    .err      (hb_err)
  );

  assign reg_rdata = reg_image(ctl);

endmodule

// File: rtl/eth_txfc_chk.sv
module eth_txfc_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       mac_en,
  input logic       gts_bit,
  input logic       fdx_bit,
  input logic       data_busy,
  input logic       tx_permit,
  input logic       pause_req,
  input logic       pause_done,
  input logic       gsc_irq,
  input logic [1:0] stat_clr,
  input logic       rx_paused,
  input logic       rx_pause_vld,
  input logic       hb_err,
  input logic       hb_open
);

  p_fdx_locked_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mac_en |=> $stable(fdx_bit));

  p_gts_blocks_r3: assert property (@(posedge clk) disable iff (!rst_n)
    gts_bit |-> !tx_permit);

  p_busy_blocks_r3: assert property (@(posedge clk) disable iff (!rst_n)
    data_busy |-> !tx_permit);

  p_preq_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pause_req && !pause_done) |=> pause_req);

  p_rxp_source_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_paused) |-> ($past(rx_pause_vld) && $past(fdx_bit)));

  p_hb_source_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hb_err) |-> $past(hb_open));

  p_irq_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (gsc_irq && !stat_clr[0]) |=> gsc_irq);

endmodule

bind eth_txfc eth_txfc_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .mac_en       (mac_en),
  .gts_bit      (gts_bit),
  .fdx_bit      (fdx_bit),
  .data_busy    (data_busy),
  .tx_permit    (tx_permit),
  .pause_req    (pause_req),
  .pause_done   (pause_done),
  .gsc_irq      (gsc_irq),
  .stat_clr     (stat_clr),
  .rx_paused    (rx_paused),
  .rx_pause_vld (rx_pause_vld),
  .hb_err       (hb_err),
  .hb_open      (hb_open)
);

// File: tb/sim_eth_txfc.sv
`timescale 1ns/1ps
module sim_eth_txfc;

  localparam int SLOT = 512;
  localparam int HBW  = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mac_en = 1'b0;
  logic        reg_wr = 1'b0;
  logic [4:0]  reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [1:0]  stat_clr = '0;
  logic        frm_start = 1'b0, frm_done = 1'b0, pause_done = 1'b0;
  logic        rx_pause_vld = 1'b0;
  logic [15:0] rx_pause_quanta = '0;
  logic        bit_tick = 1'b1, crs = 1'b0, col = 1'b0;
  logic        tx_permit, pause_req, gsc_irq, rx_paused, hb_err;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  eth_txfc #(.QUANTA_W(16), .SLOT_TICKS(SLOT), .HB_WIN(HBW)) u0 (
    .clk(clk), .rst_n(rst_n), .mac_en(mac_en), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .stat_clr(stat_clr),
    .frm_start(frm_start), .frm_done(frm_done), .pause_done(pause_done),
    .rx_pause_vld(rx_pause_vld), .rx_pause_quanta(rx_pause_quanta),
    .bit_tick(bit_tick), .crs(crs), .col(col), .tx_permit(tx_permit),
    .pause_req(pause_req), .gsc_irq(gsc_irq), .rx_paused(rx_paused),
    .hb_err(hb_err)
  );

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] d);
    reg_wr = 1'b1; reg_wdata = d; cyc(1); reg_wr = 1'b0;
  endtask

  task automatic pulse_start(); frm_start = 1'b1; cyc(1); frm_start = 1'b0; endtask
  task automatic pulse_done();  frm_done  = 1'b1; cyc(1); frm_done  = 1'b0; endtask
  task automatic pulse_pdone(); pause_done = 1'b1; cyc(1); pause_done = 1'b0; endtask
  task automatic clr(input logic [1:0] m); stat_clr = m; cyc(1); stat_clr = '0; endtask
  task automatic rxp(input logic [15:0] q);
    rx_pause_quanta = q; rx_pause_vld = 1'b1; cyc(1); rx_pause_vld = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 rdata", reg_rdata, 32'h0);
    check("R1 irq", gsc_irq, 0);
    check("R1 hb_err", hb_err, 0);
    check("R1 pause_req", pause_req, 0);
    check("R1 rx_paused", rx_paused, 0);
  endtask

  task automatic t_lock();
    wr(5'b01110);                 // fdx+hben, bit3 attempt
    check("R2 set while disabled", reg_rdata, 32'h6);
    mac_en = 1'b1;
    wr(5'b00000);
    check("R2 locked while enabled", reg_rdata, 32'h6);
  endtask

  task automatic t_gts_idle();
    check("R4 permit idle fdx", tx_permit, 1);
    wr(5'b00001);
    check("R3 permit blocked", tx_permit, 0);
    check("R3 irq not yet", gsc_irq, 0);
    cyc(1);
    check("R3 irq idle", gsc_irq, 1);
    clr(2'b01);
    check("R11 irq cleared", gsc_irq, 0);
    wr(5'b00000);
    check("R4 resume", tx_permit, 1);
  endtask

  task automatic t_gts_frame();
    pulse_start();
    check("R3 busy blocks", tx_permit, 0);
    wr(5'b00001);
    cyc(3);
    check("R3 no irq mid-frame", gsc_irq, 0);
    pulse_done();
    check("R3 irq after done edge0", gsc_irq, 0);
    cyc(1);
    check("R3 irq after frame", gsc_irq, 1);
    cyc(4);
    check("R11 irq sticky", gsc_irq, 1);
    wr(5'b00000);
    check("R4 resume after frame", tx_permit, 1);
    clr(2'b01);
  endtask

  task automatic t_send_pause();
    pulse_start();
    wr(5'b10000);
    check("R5 bit4 set", reg_rdata[4], 1);
    check("R5 no req mid-frame", pause_req, 0);
    pulse_done();
    check("R5 req waits", pause_req, 0);
    check("R5 permit held", tx_permit, 0);
    cyc(1);
    check("R5 req", pause_req, 1);
    check("R5 irq", gsc_irq, 1);
    wr(5'b00000);
    check("R5 zero write ignored", reg_rdata[4], 1);
    cyc(3);
    check("R5 req held", pause_req, 1);
    pulse_pdone();
    check("R5 req cleared", pause_req, 0);
    check("R5 bit4 cleared", reg_rdata[4], 0);
    check("R5 permit back", tx_permit, 1);
    clr(2'b01);
  endtask

  task automatic t_pause_bypass_gts();
    wr(5'b00001);
    cyc(2);
    clr(2'b01);
    wr(5'b10001);
    cyc(1);
    check("R6 req under gts", pause_req, 1);
    pulse_pdone();
    check("R6 req done", pause_req, 0);
    check("R3 still stopped", tx_permit, 0);
    wr(5'b00000);
    clr(2'b01);
  endtask

  task automatic t_rx_pause();
    rxp(16'd1);
    check("R7 paused", rx_paused, 1);
    check("R7 status bit", reg_rdata[3], 1);
    check("R7 permit low", tx_permit, 0);
    cyc(SLOT - 1);
    check("R7 still paused", rx_paused, 1);
    cyc(1);
    check("R7 pause ended", rx_paused, 0);
    check("R7 permit back", tx_permit, 1);
    // R6 bypass while paused
    rxp(16'd2);
    wr(5'b10000);
    cyc(1);
    check("R6 req under rx pause", pause_req, 1);
    pulse_pdone();
    rxp(16'd0);
    check("R8 zero quanta ends", rx_paused, 0);
    clr(2'b01);
    // R8 reload
    rxp(16'd1);
    cyc(300);
    rxp(16'd1);
    cyc(SLOT - 1);
    check("R8 reload extends", rx_paused, 1);
    cyc(1);
    check("R8 reload end", rx_paused, 0);
    // two quanta
    rxp(16'd2);
    cyc(2 * SLOT - 1);
    check("R7 q2 still", rx_paused, 1);
    cyc(1);
    check("R7 q2 end", rx_paused, 0);
  endtask

  task automatic t_duplex();
    crs = 1'b1;
    cyc(1);
    check("R9 fdx ignores crs", tx_permit, 1);
    mac_en = 1'b0;
    cyc(1);
    check("R9 disabled", tx_permit, 0);
    wr(5'b00010);
    mac_en = 1'b1;
    cyc(1);
    check("R9 hd defer", tx_permit, 0);
    crs = 1'b0;
    cyc(1);
    check("R9 hd clear", tx_permit, 1);
    rxp(16'd5);
    check("R7 ignored in hd", rx_paused, 0);
  endtask

  task automatic t_heartbeat();
    pulse_start();
    pulse_done();
    cyc(HBW - 1);
    check("R10 no err yet", hb_err, 0);
    cyc(1);
    check("R10 err set", hb_err, 1);
    cyc(3);
    check("R11 err sticky", hb_err, 1);
    clr(2'b10);
    check("R11 err cleared", hb_err, 0);
    pulse_start();
    pulse_done();
    cyc(10);
    col = 1'b1; cyc(1); col = 1'b0;
    cyc(HBW + 10);
    check("R10 col ok", hb_err, 0);
  endtask

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    t_reset();
    t_lock();
    t_gts_idle();
    t_gts_frame();
    t_send_pause();
    t_pause_bypass_gts();
    t_rx_pause();
    t_duplex();
    t_heartbeat();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule